// File: doc/BRIEF.md
# Board Control Register with Interlocks

This block is the central control register bank of a data-acquisition front-end board. Software reaches it through a simple register bus: a one-cycle write strobe and a read strobe whose data appears on the next clock edge. The control word holds four level reset lines (whole board, FIFO address counter, sequencer, front-end chips), three observe/override selects, a memory-bypass bit and a calibration-mode bit. These bits reach the neighbouring logic directly.

The control bits are coupled to each other. Calibration mode forces every active-low chip select inactive. It is also the only state in which the calibration DAC register accepts a write. A write made outside calibration mode is dropped, and a sticky flag records it. Memory bypass withdraws the sequencer's memory grant. A soft reset write clears every other piece of software state. A crate address is captured from pins while reset is held and then reads back as a fixed field.

Top module: `board_ctl_regs`

## Requirements
- R1: After `rst_n` is released, all control bits, the override values, the calibration register and the reject flag are zero. The CTRL read (address 0) returns the crate pins sampled during reset in bits 15:11.
- R2: CTRL bits 0..3 drive `board_rst_o`, `fifo_rst_o`, `seq_rst_o` and `fe_rst_o` as levels. Each stays high until software writes it back to 0.
- R3: A CTRL write with bit 0 set leaves only bit 0 set in CTRL. The same write zeroes the override values and the calibration register (value and enables).
- R4: CTRL bit 4 low: `seq_in_o` follows `seq_in_live_i`. Bit 4 high: `seq_in_o` carries the value written at address 1. A read of address 1 returns `seq_in_o`.
- R5: CTRL bit 5 selects the same way between `seq_out_live_i` and the value written at address 2, driving `seq_out_o`. A read of address 2 returns `seq_out_o`.
- R6: CTRL bit 6 high drives `fe_addr_o` from the value written at address 3. With bit 6 low, `fe_addr_o` follows `fe_addr_norm_i`.
- R7: CTRL bit 7 drives `mem_bypass_o`. While the bit is set, `seq_mem_gnt_o` is low. A grant that is pending when the bit is written stays for the clock of that write and drops on the following one. Otherwise `seq_mem_gnt_o` registers `seq_mem_req_i` one cycle late.
- R8: While CTRL bit 8 (calibration mode) is set, all 32 bits of `cs_n_o` are 1. With bit 8 clear, `cs_n_o` equals `cs_n_i`.
- R9: A write to address 4 while bit 8 is set loads bits 11:0 into `cal_val_o` and bits 15:12 into `cal_out_en_o`. A read of address 4 returns them in the same positions. While bit 8 is clear, the write has no effect.
- R10: A rejected calibration write sets the flag in CTRL bit 16. A CTRL read returns the flag and then clears it.
- R11: CTRL bits 15:11 are read-only. Writes to them do not change them.
- R12: A read of address 5 returns the current `cs_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 32 | Read data, valid the clock after `rd_en_i` |
| crate_i | input | 5 | Crate address pins, sampled during reset |
| board_rst_o | output | 1 | Whole-board reset level |
| fifo_rst_o | output | 1 | FIFO address counter reset level |
| seq_rst_o | output | 1 | Sequencer reset level |
| fe_rst_o | output | 1 | Front-end chip reset level |
| seq_in_live_i | input | 8 | Live sequencer inputs |
| seq_in_o | output | 8 | Sequencer inputs after the override select |
| seq_out_live_i | input | 8 | Live sequencer outputs |
| seq_out_o | output | 8 | Sequencer outputs after the override select |
| fe_addr_norm_i | input | 5 | Front-end address from normal logic |
| fe_addr_o | output | 5 | Front-end address lines |
| mem_bypass_o | output | 1 | Direct memory access by software |
| seq_mem_req_i | input | 1 | Sequencer memory request |
| seq_mem_gnt_o | output | 1 | Sequencer memory grant |
| cs_n_i | input | 32 | Chip selects from normal logic, active low |
| cs_n_o | output | 32 | Chip selects after calibration masking |
| cal_val_o | output | 12 | Calibration DAC value |
| cal_out_en_o | output | 4 | Calibration DAC output steering enables |

## Verification
The bench builds the block with its default parameters: 32 chip selects, 8-bit sequencer buses, a 5-bit front-end address and a 12-bit calibration value. It drives every live input with a pattern that differs from the override value behind it, so each select shows which source it passes. Because the crate pins are non-zero, a leak into or out of the read-only field becomes visible. The chip-select input mixes ones and zeros, so the masking shows as a change at the output. The grant check covers the clock on which bypass is written and the clock after it.

// File: rtl/board_ctl_pkg.sv
// Package: shared register addresses and control bit positions for the
// board control register bank. Assumes a 3-bit word address bus.
package board_ctl_pkg;
    localparam int A_CTRL    = 0;
    localparam int A_SEQ_IN  = 1;
    localparam int A_SEQ_OUT = 2;
    localparam int A_FE_ADDR = 3;
    localparam int A_CAL     = 4;
    localparam int A_CSEL    = 5;

    localparam int B_SOFT    = 0;
    localparam int B_FIFO    = 1;
    localparam int B_SEQ     = 2;
    localparam int B_FE      = 3;
    localparam int B_OVR_IN  = 4;
    localparam int B_OVR_OUT = 5;
    localparam int B_ADDR    = 6;
    localparam int B_BYPASS  = 7;
    localparam int B_CAL     = 8;
    localparam int CTRL_BITS = 9;

    localparam int CRATE_LSB = 11;
    localparam int REJ_BIT   = 16;

    typedef struct packed {
        logic cal;
        logic bypass;
        logic addr_ovr;
        logic out_ovr;
        logic in_ovr;
        logic fe_rst;
        logic seq_rst;
        logic fifo_rst;
        logic soft_rst;
    } ctrl_t;
endpackage

// File: rtl/board_ctl_core.sv
// Module: control word, crate capture and reject flag.
// Assumes at most one bus access per clock; a soft reset write keeps only
// the soft reset bit. Crate pins are sampled only while rst_n is low.
module board_ctl_core
    import board_ctl_pkg::*;
#(
    parameter int CRATE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               rd_ctrl,
    input  logic [CTRL_BITS-1:0] wr_bits,
    input  logic               cal_reject,
    input  logic [CRATE_W-1:0] crate_i,
    output ctrl_t              ctrl_q,
    output logic [CRATE_W-1:0] crate_q,
    output logic               reject_q,
    output logic               soft_clr
);
    // Soft reset request: a control write with the soft bit high
    assign soft_clr = wr_ctrl && wr_bits[B_SOFT];

    // Control word update; soft reset keeps only the soft bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            if (wr_bits[B_SOFT]) begin
                ctrl_q          <= '0;
                ctrl_q.soft_rst <= 1'b1;
            end else begin
                ctrl_q <= ctrl_t'(wr_bits);
            end
        end
    end

    // Crate address capture while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crate_q <= crate_i;
        end
    end

    // Sticky reject flag: set by a dropped calibration write, cleared by read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject_q <= 1'b0;
        end else if (soft_clr) begin
            reject_q <= 1'b0;
        end else if (cal_reject) begin
            reject_q <= 1'b1;
        end else if (rd_ctrl) begin
            reject_q <= 1'b0;
        end
    end

    // R3
    soft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (ctrl_q == ctrl_t'(CTRL_BITS'(1))));
    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));
    // R10
    reject_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_reject && !soft_clr) |=> reject_q);
endmodule

// File: rtl/board_sw_regs.sv
// Module: software override values for sequencer inputs and outputs and
// the front-end address. Assumes soft_clr never coincides with a write here.
module board_sw_regs #(
    parameter int SEQ_W  = 8,
    parameter int FE_A_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_in,
    input  logic              wr_out,
    input  logic              wr_addr,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic [FE_A_W-1:0] wr_fe,
    output logic [SEQ_W-1:0]  in_sw_q,
    output logic [SEQ_W-1:0]  out_sw_q,
    output logic [FE_A_W-1:0] fe_sw_q
);
    // Sequencer input override value
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) in_sw_q <= '0;
        else if (wr_in)         in_sw_q <= wr_seq;
    end

    // Sequencer output override value
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) out_sw_q <= '0;
        else if (wr_out)        out_sw_q <= wr_seq;
    end

    // Front-end address override value
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) fe_sw_q <= '0;
        else if (wr_addr)       fe_sw_q <= wr_fe;
    end

    // R3
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (in_sw_q == '0 && out_sw_q == '0 && fe_sw_q == '0));
endmodule

// File: rtl/board_cal_dac.sv
// Module: calibration DAC value and output-steering enables, writable only
// in calibration mode; a dropped write raises a one-cycle reject pulse.
// Assumes soft_clr acts as the master reset for this register.
module board_cal_dac #(
    parameter int CAL_W = 12,
    parameter int CAL_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             cal_mode,
    input  logic             wr_cal,
    input  logic [CAL_W-1:0] wr_val,
    input  logic [CAL_N-1:0] wr_en_bits,
    output logic [CAL_W-1:0] val_q,
    output logic [CAL_N-1:0] oe_q,
    output logic             reject
);
    // A write outside calibration mode is refused
    assign reject = wr_cal && !cal_mode;

    // Value and enable register, gated by calibration mode
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            val_q <= '0;
            oe_q  <= '0;
        end else if (wr_cal && cal_mode) begin
            val_q <= wr_val;
            oe_q  <= wr_en_bits;
        end
    end

    // R9
    cal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_mode && !soft_clr) |=> $stable({val_q, oe_q}));
endmodule

// File: rtl/board_sig_route.sv
// Module: applies control bits to neighbouring logic: override selects,
// chip-select masking and the registered sequencer memory grant.
// Assumes chip selects are active low.
module board_sig_route
    import board_ctl_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int FE_A_W = 5,
    parameter int NCS    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [SEQ_W-1:0]  in_live,
    input  logic [SEQ_W-1:0]  in_sw,
    input  logic [SEQ_W-1:0]  out_live,
    input  logic [SEQ_W-1:0]  out_sw,
    input  logic [FE_A_W-1:0] fe_norm,
    input  logic [FE_A_W-1:0] fe_sw,
    input  logic [NCS-1:0]    cs_n_in,
    input  logic              mem_req,
    output logic [SEQ_W-1:0]  seq_in,
    output logic [SEQ_W-1:0]  seq_out,
    output logic [FE_A_W-1:0] fe_addr,
    output logic [NCS-1:0]    cs_n,
    output logic              mem_gnt
);
    // Observe/override selects
    always_comb begin
        seq_in  = ctrl.in_ovr   ? in_sw  : in_live;
        seq_out = ctrl.out_ovr  ? out_sw : out_live;
        fe_addr = ctrl.addr_ovr ? fe_sw  : fe_norm;
    end

    // Chip-select masking, one gate per line
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = cs_n_in[i] | ctrl.cal;
    end

    // Sequencer memory grant, withheld during memory bypass
    always_ff @(posedge clk) begin
        if (!rst_n) mem_gnt <= 1'b0;
        else        mem_gnt <= mem_req && !ctrl.bypass;
    end

    // R7
    bypass_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.bypass |=> !mem_gnt);
endmodule

// File: rtl/board_ctl_regs.sv
// Module: top of the board control register bank. Decodes the register
// bus, registers read data one clock after rd_en_i, and ties the control,
// override, calibration and routing submodules together.
// Assumes wr_en_i and rd_en_i are never high in the same cycle.
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int CRATE_W = 5,
    parameter int SEQ_W   = 8,
    parameter int FE_A_W  = 5,
    parameter int NCS     = 32,
    parameter int CAL_W   = 12,
    parameter int CAL_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    input  logic [CRATE_W-1:0] crate_i,
    output logic              board_rst_o,
    output logic              fifo_rst_o,
    output logic              seq_rst_o,
    output logic              fe_rst_o,
    input  logic [SEQ_W-1:0]  seq_in_live_i,
    output logic [SEQ_W-1:0]  seq_in_o,
    input  logic [SEQ_W-1:0]  seq_out_live_i,
    output logic [SEQ_W-1:0]  seq_out_o,
    input  logic [FE_A_W-1:0] fe_addr_norm_i,
    output logic [FE_A_W-1:0] fe_addr_o,
    output logic              mem_bypass_o,
    input  logic              seq_mem_req_i,
    output logic              seq_mem_gnt_o,
    input  logic [NCS-1:0]    cs_n_i,
    output logic [NCS-1:0]    cs_n_o,
    output logic [CAL_W-1:0]  cal_val_o,
    output logic [CAL_N-1:0]  cal_out_en_o
);
    localparam int CAL_TOP = CAL_W + CAL_N;

    ctrl_t              ctrl_q;
    logic [CRATE_W-1:0] crate_q;
    logic               reject_q, soft_clr, cal_reject;
    logic [SEQ_W-1:0]   in_sw_q, out_sw_q;
    logic [FE_A_W-1:0]  fe_sw_q;
    logic               sel_ctrl, sel_in, sel_out, sel_fe, sel_cal, sel_cs;
    logic [31:0]        rd_mux;

    // Address decode
    always_comb begin
        sel_ctrl = addr_i == ADDR_W'(A_CTRL);
        sel_in   = addr_i == ADDR_W'(A_SEQ_IN);
        sel_out  = addr_i == ADDR_W'(A_SEQ_OUT);
        sel_fe   = addr_i == ADDR_W'(A_FE_ADDR);
        sel_cal  = addr_i == ADDR_W'(A_CAL);
        sel_cs   = addr_i == ADDR_W'(A_CSEL);
    end

    board_ctl_core #(.CRATE_W(CRATE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_en_i && sel_ctrl),
        .rd_ctrl   (rd_en_i && sel_ctrl),
        .wr_bits   (wr_data_i[CTRL_BITS-1:0]),
        .cal_reject(cal_reject),
        .crate_i   (crate_i),
        .ctrl_q    (ctrl_q),
        .crate_q   (crate_q),
        .reject_q  (reject_q),
        .soft_clr  (soft_clr)
    );

    board_sw_regs #(.SEQ_W(SEQ_W), .FE_A_W(FE_A_W)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(soft_clr),
        .wr_in   (wr_en_i && sel_in),
        .wr_out  (wr_en_i && sel_out),
        .wr_addr (wr_en_i && sel_fe),
        .wr_seq  (wr_data_i[SEQ_W-1:0]),
        .wr_fe   (wr_data_i[FE_A_W-1:0]),
        .in_sw_q (in_sw_q),
        .out_sw_q(out_sw_q),
        .fe_sw_q (fe_sw_q)
    );

    board_cal_dac #(.CAL_W(CAL_W), .CAL_N(CAL_N)) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .cal_mode  (ctrl_q.cal),
        .wr_cal    (wr_en_i && sel_cal),
        .wr_val    (wr_data_i[CAL_W-1:0]),
        .wr_en_bits(wr_data_i[CAL_TOP-1:CAL_W]),
        .val_q     (cal_val_o),
        .oe_q      (cal_out_en_o),
        .reject    (cal_reject)
    );

    board_sig_route #(.SEQ_W(SEQ_W), .FE_A_W(FE_A_W), .NCS(NCS)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl_q),
        .in_live (seq_in_live_i),
        .in_sw   (in_sw_q),
        .out_live(seq_out_live_i),
        .out_sw  (out_sw_q),
        .fe_norm (fe_addr_norm_i),
        .fe_sw   (fe_sw_q),
        .cs_n_in (cs_n_i),
        .mem_req (seq_mem_req_i),
        .seq_in  (seq_in_o),
        .seq_out (seq_out_o),
        .fe_addr (fe_addr_o),
        .cs_n    (cs_n_o),
        .mem_gnt (seq_mem_gnt_o)
    );

    // Level outputs taken straight from the control word
    always_comb begin
        board_rst_o  = ctrl_q.soft_rst;
        fifo_rst_o   = ctrl_q.fifo_rst;
        seq_rst_o    = ctrl_q.seq_rst;
        fe_rst_o     = ctrl_q.fe_rst;
        mem_bypass_o = ctrl_q.bypass;
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux[CTRL_BITS-1:0]                 = ctrl_q;
            rd_mux[CRATE_LSB+CRATE_W-1:CRATE_LSB] = crate_q;
            rd_mux[REJ_BIT]                       = reject_q;
        end else if (sel_in) begin
            rd_mux[SEQ_W-1:0] = seq_in_o;
        end else if (sel_out) begin
            rd_mux[SEQ_W-1:0] = seq_out_o;
        end else if (sel_fe) begin
            rd_mux[FE_A_W-1:0] = fe_addr_o;
        end else if (sel_cal) begin
            rd_mux[CAL_TOP-1:0] = {cal_out_en_o, cal_val_o};
        end else if (sel_cs) begin
            rd_mux[NCS-1:0] = cs_n_o;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end

    // R10
    rej_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel_ctrl && !cal_reject) |=> !reject_q);
endmodule

// File: tb/tb_board_ctl_regs.sv
module tb_board_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  crate = 5'h15;
    logic        board_rst, fifo_rst, seq_rst, fe_rst;
    logic [7:0]  in_live = 8'hA5, in_o, out_live = 8'h0F, out_o;
    logic [4:0]  fe_norm = 5'h07, fe_o;
    logic        bypass, req = 1'b1, gnt;
    logic [31:0] cs_in = 32'h1234_5678, cs_o;
    logic [11:0] cal_val;
    logic [3:0]  cal_oe;

    int n_chk = 0, n_fail = 0;

    localparam logic [7:0]  SW_IN = 8'h3C, SW_OUT = 8'hF0;
    localparam logic [4:0]  SW_FE = 5'h19;
    localparam logic [31:0] CRATE_RD = 32'h0000_A800;

    // {ctrl word, expected {fifo,seq,fe,in_sw,out_sw,addr_sw,bypass,cal}}
    localparam logic [16:0] VEC [10] = '{
        {9'h002, 8'b1000_0000}, {9'h004, 8'b0100_0000},
        {9'h008, 8'b0010_0000}, {9'h010, 8'b0001_0000},
        {9'h020, 8'b0000_1000}, {9'h040, 8'b0000_0100},
        {9'h080, 8'b0000_0010}, {9'h100, 8'b0000_0001},
        {9'h1FE, 8'b1111_1111}, {9'h000, 8'b0000_0000}};

    always #2.5 clk = ~clk;

    board_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
        .crate_i(crate), .board_rst_o(board_rst), .fifo_rst_o(fifo_rst),
        .seq_rst_o(seq_rst), .fe_rst_o(fe_rst),
        .seq_in_live_i(in_live), .seq_in_o(in_o),
        .seq_out_live_i(out_live), .seq_out_o(out_o),
        .fe_addr_norm_i(fe_norm), .fe_addr_o(fe_o),
        .mem_bypass_o(bypass), .seq_mem_req_i(req), .seq_mem_gnt_o(gnt),
        .cs_n_i(cs_in), .cs_n_o(cs_o),
        .cal_val_o(cal_val), .cal_out_en_o(cal_oe));

    task automatic chk(input string req_tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin : watchdog
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        crate = 5'h0A;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d);
        chk("R1 ctrl", d, CRATE_RD);
        chk("R1 resets", {28'd0, board_rst, fifo_rst, seq_rst, fe_rst}, 32'd0);
        rd(3'd4, d);
        chk("R1 cal", d, 32'd0);
        chk("R8 cs pass", cs_o, cs_in);
        chk("R7 gnt", {31'd0, gnt}, 32'd1);

        wr(3'd1, {8'd0, SW_IN});
        wr(3'd2, {8'd0, SW_OUT});
        wr(3'd3, {11'd0, SW_FE});

        // vector walk over control patterns
        foreach (VEC[i]) begin
            logic [7:0] e;
            e = VEC[i][7:0];
            wr(3'd0, {7'd0, VEC[i][16:8]});
            chk("R2 reset lines", {29'd0, fifo_rst, seq_rst, fe_rst},
                {29'd0, e[7], e[6], e[5]});
            chk("R4 seq_in", {24'd0, in_o}, {24'd0, e[4] ? SW_IN : in_live});
            chk("R5 seq_out", {24'd0, out_o}, {24'd0, e[3] ? SW_OUT : out_live});
            chk("R6 fe_addr", {27'd0, fe_o}, {27'd0, e[2] ? SW_FE : fe_norm});
            chk("R7 bypass", {31'd0, bypass}, {31'd0, e[1]});
            chk("R8 cs mask", cs_o, e[0] ? 32'hFFFF_FFFF : cs_in);
            @(negedge clk);
            chk("R7 gnt", {31'd0, gnt}, {31'd0, !e[1]});
            rd(3'd1, d);
            chk("R4 readback", d, {24'd0, e[4] ? SW_IN : in_live});
            rd(3'd2, d);
            chk("R5 readback", d, {24'd0, e[3] ? SW_OUT : out_live});
        end

        // R7 grant withdrawn one cycle after bypass set
        wr(3'd0, 16'h0080);
        chk("R7 gnt same cycle", {31'd0, gnt}, 32'd1);
        @(negedge clk);
        chk("R7 gnt withdrawn", {31'd0, gnt}, 32'd0);
        wr(3'd0, 16'h0000);
        @(negedge clk);
        chk("R7 gnt restored", {31'd0, gnt}, 32'd1);

        // R9 / R10 rejected calibration write
        wr(3'd4, 16'hFABC);
        chk("R9 rejected val", {16'd0, cal_oe, cal_val}, 32'd0);
        rd(3'd0, d);
        chk("R10 flag set", d, CRATE_RD | 32'h0001_0000);
        rd(3'd0, d);
        chk("R10 flag cleared", d, CRATE_RD);

        // R9 accepted write, R12 chip select readback
        wr(3'd0, 16'h0100);
        wr(3'd4, 16'h5ABC);
        chk("R9 outputs", {16'd0, cal_oe, cal_val}, 32'h0000_5ABC);
        rd(3'd4, d);
        chk("R9 readback", d, 32'h0000_5ABC);
        rd(3'd5, d);
        chk("R12 masked", d, 32'hFFFF_FFFF);
        rd(3'd0, d);
        chk("R10 no flag", d, CRATE_RD | 32'h100);

        // R11 crate field read-only
        wr(3'd0, 16'hF900);
        rd(3'd0, d);
        chk("R11 crate", d, CRATE_RD | 32'h100);

        // R3 soft reset clears the rest, R2 level held
        wr(3'd0, 16'h0170);
        wr(3'd0, 16'h0001);
        chk("R3 board_rst", {31'd0, board_rst}, 32'd1);
        chk("R3 cal cleared", {16'd0, cal_oe, cal_val}, 32'd0);
        rd(3'd0, d);
        chk("R3 ctrl", d, CRATE_RD | 32'h1);
        repeat (5) @(negedge clk);
        chk("R2 held", {31'd0, board_rst}, 32'd1);
        wr(3'd0, 16'h0010);
        chk("R2 cleared", {31'd0, board_rst}, 32'd0);
        rd(3'd1, d);
        chk("R3 sw cleared", d, 32'd0);
        wr(3'd0, 16'h0000);
        rd(3'd5, d);
        chk("R12 pass", d, cs_in);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule